// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block takes characters from a 16-entry buffer and sends them one at a time on a single serial line. Each character is framed with a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. The frame shape comes from a 6-bit line-control input. That value is captured when each character leaves the buffer, so software may change it at any time without damaging a frame already on the line.

Bit timing comes from a 16-bit divisor. A counter makes one tick every `divisor` clock cycles, with zero treated as one. Sixteen ticks make one bit period. The counter restarts whenever a character is loaded, so every start bit lasts a whole bit period. Two status outputs show whether the buffer is empty and whether the whole transmitter is quiet.

Top module: `serial_tx_core`

## Requirements
- R1: `txd` is 1 after reset and whenever no frame is being sent.
- R2: A frame opens with `txd` at 0 for one bit period. A frame starts on the clock edge after the buffer becomes non-empty while the transmitter is idle.
- R3: Data bits follow the start bit, least significant bit first. `line_ctrl[1:0]` gives the count: 00 for 5, 01 for 6, 10 for 7 and 11 for 8 bits.
- R4: `line_ctrl[2]`=0 gives one stop bit and 1 gives two. Stop bits are always 1.
- R5: With `line_ctrl[3]`=1, one parity bit is placed between the data and the stop bits. With `line_ctrl[4]`=1 the data bits plus the parity bit hold an even number of ones; with 0, an odd number.
- R6: With `line_ctrl[3]`=1 and `line_ctrl[5]`=1, the parity bit is the constant `~line_ctrl[4]`.
- R7: The buffer holds 16 characters. A write made while it holds 16 is dropped, and no frame is ever sent for it.
- R8: `fifo_empty` is 1 exactly when the buffer holds no character.
- R9: `tx_idle` is 1 exactly when the buffer is empty and no frame is in progress.
- R10: `line_ctrl` is sampled when a character is loaded. A change made during a frame affects only later frames.
- R11: If a character is waiting when the last stop bit ends, its start bit follows with no idle gap.
- R12: Every bit lasts 16 × `divisor` clock cycles, with a divisor of 0 acting as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the buffer |
| wr_data | input | 8 | Character to send |
| line_ctrl | input | 6 | Frame format: length [1:0], stop [2], parity enable [3], even [4], stick [5] |
| divisor | input | 16 | Clock cycles per tick; 16 ticks per bit |
| txd | output | 1 | Serial line |
| fifo_empty | output | 1 | Buffer holds no character |
| tx_idle | output | 1 | Buffer empty and no frame in progress |

## Verification
The bench sweeps all 64 line-control values with single frames. This separates errors in data length, stop count, parity sense and stick parity, since each of these changes a different bit position. Divisors of 0, 1, 2 and 3 check that each bit period scales and that zero acts as one. Directed cases then cover an 18-write burst, which shows the overflow drop and back-to-back framing, and a line-control change in mid-frame, which shows the per-frame capture. Random bursts of random data, format and divisor are finally compared bit by bit, at the first, middle and last cycle of every bit, against frames that the bench builds itself.

// File: rtl/serial_tx_pkg.sv
// Shared types for the serial transmitter.
// Assumes 8-bit characters and 16 ticks per bit period.
package serial_tx_pkg;
    localparam int CHAR_W     = 8;
    localparam int OVERSAMPLE = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Field layout of the 6-bit line-control input (MSB first).
    typedef struct packed {
        logic       stick;     // [5] parity forced to ~even
        logic       even;      // [4] even (1) or odd (0) parity
        logic       par_en;    // [3] parity bit present
        logic       two_stop;  // [2] two stop bits
        logic [1:0] len;       // [1:0] 5..8 data bits
    } line_ctrl_t;
endpackage

// File: rtl/tx_bit_timer.sv
// Makes a one-cycle bit_end pulse every OVS x divisor cycles.
// A divisor of zero acts as one. The restart input clears both counters
// so that the next bit period begins on the following cycle.
module tx_bit_timer #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_end
);
    localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic [SUB_W-1:0] sub_cnt;
    logic [DIV_W-1:0] eff_div;
    logic             tick;

    // Zero divisor is treated as one; a tick ends each divisor span.
    always_comb begin
        eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
        tick    = (div_cnt >= eff_div - DIV_W'(1));
        bit_end = tick && (sub_cnt == SUB_W'(OVS - 1));
    end

    // Advance the divisor counter and the tick-within-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_cnt <= '0;
            sub_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
            sub_cnt <= (sub_cnt == SUB_W'(OVS - 1)) ? '0 : sub_cnt + SUB_W'(1);
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    AST_RESTART_FULL_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !bit_end); // R12
endmodule

// File: rtl/tx_fifo.sv
// Character buffer DEPTH entries deep, with first-word fall-through read.
// A write while full is dropped. The reader must pop only when not empty.
module tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    // Accept writes only with room; pops only with data.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        do_wr   = wr_en && !full;
        do_rd   = rd_en && !empty;
        rd_data = mem[rd_ptr];
    end

    // Store accepted characters.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R7
    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en |=> full && count == CW'(DEPTH)); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty); // R8
endmodule

// File: rtl/tx_framer.sv
// Frame sequencer: start, data (LSB first), optional parity, stop bits.
// Loads a character when idle, or at the end of the last stop bit, if the
// buffer is not empty. It captures the line control at that moment.
// Assumes bit_end restarts its period on the cycle after restart.
module tx_framer
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    input  line_ctrl_t        line_ctrl,
    output logic              pop,
    output logic              restart,
    output logic              txd,
    output logic              busy
);
    tx_state_e         state;
    line_ctrl_t        ctrl_q;
    logic [CHAR_W-1:0] shreg;
    logic [2:0]        bit_idx;
    logic              stop_idx;
    logic              par_bit;
    logic              last_stop;
    logic              load;
    logic [CHAR_W-1:0] len_mask;
    logic              ones_odd;
    logic              par_next;

    // Decide when to take the next character and work out its parity.
    always_comb begin
        last_stop = (state == ST_STOP) && bit_end && (stop_idx == ctrl_q.two_stop);
        load      = ((state == ST_IDLE) || last_stop) && !fifo_empty;
        pop       = load;
        restart   = load;
        busy      = (state != ST_IDLE);
        len_mask  = 8'hFF >> (2'd3 - line_ctrl.len);
        ones_odd  = ^(fifo_data & len_mask);
        if (line_ctrl.stick) par_next = ~line_ctrl.even;
        else                 par_next = line_ctrl.even ? ones_odd : ~ones_odd;
    end

    // Step through the frame one bit period at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            txd      <= 1'b1;
            ctrl_q   <= '0;
            shreg    <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            par_bit  <= 1'b0;
        end else if (load) begin
            state    <= ST_START;
            txd      <= 1'b0;
            ctrl_q   <= line_ctrl;
            shreg    <= fifo_data;
            par_bit  <= par_next;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
        end else if (bit_end) begin
            case (state)
                ST_START: begin
                    state <= ST_DATA;
                    txd   <= shreg[0];
                    shreg <= shreg >> 1;
                end
                ST_DATA: begin
                    if (bit_idx == {1'b1, ctrl_q.len}) begin
                        state <= ctrl_q.par_en ? ST_PARITY : ST_STOP;
                        txd   <= ctrl_q.par_en ? par_bit : 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                        txd     <= shreg[0];
                        shreg   <= shreg >> 1;
                    end
                end
                ST_PARITY: begin
                    state <= ST_STOP;
                    txd   <= 1'b1;
                end
                ST_STOP: begin
                    if (stop_idx == ctrl_q.two_stop) state <= ST_IDLE;
                    else                             stop_idx <= 1'b1;
                    txd <= 1'b1;
                end
                default: begin
                    state <= ST_IDLE;
                    txd   <= 1'b1;
                end
            endcase
        end
    end

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> txd); // R1
    AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_START |-> !txd); // R2
    AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STOP |-> txd); // R4
    AST_PARITY_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PARITY |-> ctrl_q.par_en); // R5
    AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_START && !bit_end |=> state == ST_START); // R2
endmodule

// File: rtl/serial_tx_core.sv
// Top of the serial transmitter: character buffer, bit timer and framer.
// Assumes divisor stays stable while a frame is on the line.
module serial_tx_core #(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [5:0]  line_ctrl,
    input  logic [15:0] divisor,
    output logic        txd,
    output logic        fifo_empty,
    output logic        tx_idle
);
    import serial_tx_pkg::*;

    logic [CHAR_W-1:0] head_data;
    logic              pop, restart, bit_end, busy, full;
    logic [DIV_W-1:0]  div_in;

    // Size the divisor input to the timer width.
    always_comb div_in = DIV_W'(divisor);

    tx_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .rd_data(head_data), .empty(fifo_empty), .full(full)
    );

    tx_bit_timer #(.DIV_W(DIV_W), .OVS(OVERSAMPLE)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .divisor(div_in),
        .bit_end(bit_end)
    );

    tx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .fifo_empty(fifo_empty),
        .fifo_data(head_data), .line_ctrl(line_ctrl_t'(line_ctrl)),
        .pop(pop), .restart(restart), .txd(txd), .busy(busy)
    );

    // Quiet only with nothing buffered and nothing on the line.
    always_comb tx_idle = fifo_empty && !busy;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd); // R9
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !fifo_empty && !tx_idle); // R8
endmodule

// File: tb/serial_tx_core_tb.sv
module serial_tx_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [5:0]  line_ctrl = '0;
    logic [15:0] divisor = 16'd1;
    logic        txd, fifo_empty, tx_idle;

    int n_run  = 0;
    int n_fail = 0;

    serial_tx_core u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .line_ctrl(line_ctrl), .divisor(divisor), .txd(txd),
        .fifo_empty(fifo_empty), .tx_idle(tx_idle)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected line sequence: start, data LSB first, parity, stops.
    function automatic int build(input logic [7:0] d, input logic [5:0] c,
                                 output logic [11:0] bits);
        int len = 5 + int'(c[1:0]);
        int idx = 1;
        bit ones = 1'b0;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < len; i++) begin
            bits[idx] = d[i];
            ones ^= d[i];
            idx++;
        end
        if (c[3]) begin
            bits[idx] = c[5] ? ~c[4] : (c[4] ? ones : ~ones);
            idx++;
        end
        return idx + 1 + int'(c[2]);
    endfunction

    task automatic wr_byte(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Follows one frame; every cycle of every bit must match.
    task automatic rx_frame(input logic [7:0] d, input logic [5:0] c,
                            input int dv, input bit b2b, input string tag);
        logic [11:0] eb;
        logic [11:0] ab = '1;
        bit bad = 1'b0;
        int waited = 0;
        int n = build(d, c, eb);
        int p = 16 * ((dv == 0) ? 1 : dv);
        if (b2b) begin
            @(negedge clk);
            check(txd == 1'b0, "R11", "start right after stop", txd, 0);
        end else begin
            while (txd !== 1'b0 && waited < 400) begin
                @(negedge clk);
                waited++;
            end
            check(txd == 1'b0, "R2", "start bit appears", txd, 0);
        end
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < p; k++) begin
                if (i != 0 || k != 0) @(negedge clk);
                if (txd !== eb[i]) bad = 1'b1;
                if (k == p / 2) ab[i] = txd;
            end
        end
        check(!bad, tag, $sformatf("frame d=%0h c=%0h div=%0d", d, c, dv),
              32'(ab), 32'(eb));
    endtask

    task automatic expect_quiet(input string req);
        @(negedge clk);
        check(txd == 1'b1 && tx_idle == 1'b1 && fifo_empty == 1'b1, req,
              "quiet after last frame", {txd, tx_idle, fifo_empty}, 3'b111);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] arr [0:17];
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R1", "txd in reset", txd, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1", "txd after reset", txd, 1);
        check(fifo_empty == 1'b1, "R8", "fifo_empty after reset", fifo_empty, 1);
        check(tx_idle == 1'b1, "R9", "tx_idle after reset", tx_idle, 1);

        // Every line-control value, one frame each (R3 R4 R5 R6).
        divisor = 16'd1;
        for (int c = 0; c < 64; c++) begin
            logic [7:0] d = 8'($urandom);
            line_ctrl = 6'(c);
            fork
                wr_byte(d);
                rx_frame(d, 6'(c), 1, 1'b0,
                         c[3] ? (c[5] ? "R6" : "R5") : "R3 R4");
            join
            expect_quiet("R1");
        end

        // Divisor scaling, including zero (R12).
        for (int dv = 0; dv < 4; dv++) begin
            logic [7:0] d = 8'($urandom);
            divisor = 16'(dv);
            line_ctrl = 6'b001111;
            fork
                wr_byte(d);
                rx_frame(d, 6'b001111, dv, 1'b0, "R12");
            join
            expect_quiet("R12");
        end

        // Status while a lone frame is on the line (R8 R9).
        divisor = 16'd1;
        line_ctrl = 6'b000011;
        fork
            begin
                wr_byte(8'hA5);
                repeat (3) @(negedge clk);
                check(fifo_empty == 1'b1, "R8", "empty while sending", fifo_empty, 1);
                check(tx_idle == 1'b0, "R9", "not idle while sending", tx_idle, 0);
            end
            rx_frame(8'hA5, 6'b000011, 1, 1'b0, "R3");
        join
        expect_quiet("R9");

        // Burst of 18: one goes out at once, 16 fill, the last is dropped (R7).
        line_ctrl = 6'b000000;
        for (int i = 0; i < 18; i++) arr[i] = 8'($urandom);
        fork
            begin
                for (int i = 0; i < 18; i++) wr_byte(arr[i]);
                check(fifo_empty == 1'b0, "R8", "not empty after burst", fifo_empty, 0);
                check(tx_idle == 1'b0, "R9", "busy after burst", tx_idle, 0);
            end
            for (int i = 0; i < 17; i++) rx_frame(arr[i], 6'b000000, 1, i > 0, "R7");
        join
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) begin
                check(1'b0, "R7", "dropped write sent", txd, 1);
                break;
            end
        end
        check(tx_idle == 1'b1, "R7", "idle after 17 frames", tx_idle, 1);

        // Line control changed mid-frame (R10).
        line_ctrl = 6'b011011;
        fork
            begin
                wr_byte(8'h3C);
                wr_byte(8'hC3);
                repeat (40) @(negedge clk);
                line_ctrl = 6'b100100;
            end
            begin
                rx_frame(8'h3C, 6'b011011, 1, 1'b0, "R10");
                rx_frame(8'hC3, 6'b100100, 1, 1'b1, "R10");
            end
        join
        expect_quiet("R10");

        // Random bursts of format, divisor and data.
        for (int b = 0; b < 25; b++) begin
            logic [5:0] c = 6'($urandom);
            int dv = 1 + int'($urandom % 2);
            int n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) arr[i] = 8'($urandom);
            line_ctrl = c;
            divisor = 16'(dv);
            fork
                for (int i = 0; i < n; i++) wr_byte(arr[i]);
                for (int i = 0; i < n; i++) rx_frame(arr[i], c, dv, i > 0, "R3 R11");
            join
            expect_quiet("R1");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule